// File: doc/BRIEF.md
# Watchdog Counter with Selectable Prescaler

This block is an 8-bit watchdog up-counter driven by a free-running 14-bit clock divider. A 3-bit select field picks one of eight fixed divide ratios of the block clock: 1, 64, 128, 256, 512, 1024, 4096 or 16384. Each time the selected divider tap completes a period, the divider produces a single-cycle tick and the counter advances by one. When the counter wraps from 0xFF to 0x00, the block raises a one-cycle overflow pulse and sets a sticky flag that software can read.

Software reaches the block through a small register bus with combinational reads. Address 0 is the control/status byte and address 1 is the counter. Clearing the run bit freezes the counter at its current value and resets the divider. A change of divide ratio is accepted only while the counter is stopped, because changing the ratio while it runs would make the count irregular.

Top module: `wdog_prescaled`

## Requirements
- R1: After synchronous reset, the control byte reads 0x18, the counter reads 0x00 and `ovf_pulse` is low.
- R2: Control bits 4 and 3 always read 1, and bit 6 always reads 0. Writes to these bits have no effect. Addresses 2 and 3 read 0x00.
- R3: Control bit 5 is the run bit (1 = count, 0 = stop). While it is 0 the counter keeps its value.
- R4: Control bits 2:0 select the divide ratio: 000=1, 001=64, 010=128, 011=256, 100=512, 101=1024, 110=4096, 111=16384. While the block runs at ratio R, the counter advances once every R clock cycles.
- R5: A write to bits 2:0 takes effect only if the run bit was 0 before that write. This includes a write that sets the run bit at the same time. If the run bit was 1, the old selection is kept.
- R6: Clearing the run bit resets the divider. After the edge that writes the run bit to 1, the first increment happens at the R-th following clock edge.
- R7: When the counter wraps from 0xFF to 0x00, `ovf_pulse` is high for exactly one cycle. That cycle is the first cycle in which the counter reads 0x00.
- R8: Control bit 7 is a sticky overflow flag that is set on each wrap. Writing 0 to it clears it, and writing 1 to it has no effect.
- R9: A write to address 1 loads the counter at that clock edge. It takes priority over an increment in the same cycle, so that increment is not applied and no wrap results from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 2 | Register address: 0 control, 1 counter |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| ovf_pulse | output | 1 | One-cycle pulse on counter wrap |

## Verification
A wrong divider state shows up as an increment one or more cycles too early or too late. The bench detects it with an exact count read back after a known number of edges, as late as one full selected period after enable. A select field that changed while the timer was running is caught by the next control read. A missed or doubled wrap shows up in the pulse count and in the flag, in the first cycle after the counter passes 0xFF.

// File: rtl/wdp_pkg.sv
package wdp_pkg;

    localparam int DATA_W   = 8;
    localparam int CNT_W    = 8;
    localparam int DIV_W    = 14;
    localparam int SEL_W    = 3;
    localparam int NUM_TAPS = 1 << SEL_W;

    localparam int BIT_FLAG = 7;
    localparam int BIT_RUN  = 5;
    localparam logic [DATA_W-1:0] RSV_ONES = 8'h18;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CNT  = 2'd1;

    typedef enum logic [SEL_W-1:0] {
        RATIO_1     = 3'd0,
        RATIO_64    = 3'd1,
        RATIO_128   = 3'd2,
        RATIO_256   = 3'd3,
        RATIO_512   = 3'd4,
        RATIO_1024  = 3'd5,
        RATIO_4096  = 3'd6,
        RATIO_16384 = 3'd7
    } ratio_sel_e;

    typedef struct packed {
        logic       flag;
        logic       run;
        ratio_sel_e sel;
    } ctrl_t;

    // log2 of the divide ratio for each select code
    function automatic int unsigned tap_shift(input int unsigned idx);
        case (idx)
            0:       return 0;
            1:       return 6;
            2:       return 7;
            3:       return 8;
            4:       return 9;
            5:       return 10;
            6:       return 12;
            default: return 14;
        endcase
    endfunction

    function automatic logic [DIV_W-1:0] tap_mask(input int unsigned idx);
        logic [DIV_W:0] one_hot;
        one_hot = (DIV_W+1)'(1) << tap_shift(idx);
        return DIV_W'(one_hot - 1'b1);
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_image(input ctrl_t c);
        logic [DATA_W-1:0] v;
        v = RSV_ONES;
        v[BIT_FLAG] = c.flag;
        v[BIT_RUN]  = c.run;
        v[SEL_W-1:0] = c.sel;
        return v;
    endfunction

endpackage

// File: rtl/wdp_regs.sv
module wdp_regs
    import wdp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ctrl,
    input  logic             wr_flag,
    input  logic             wr_run,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic             wrap_evt,
    output ctrl_t            ctrl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.flag <= 1'b0;
            ctrl_q.run  <= 1'b0;
            ctrl_q.sel  <= RATIO_1;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.run <= wr_run;
                if (!ctrl_q.run)
                    ctrl_q.sel <= ratio_sel_e'(wr_sel);
                if (!wr_flag)
                    ctrl_q.flag <= 1'b0;
            end
            if (wrap_evt)
                ctrl_q.flag <= 1'b1;
        end
    end

    // R5: selection frozen while running
    p_sel_locked_r5: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.run |=> ctrl_q.sel == $past(ctrl_q.sel));

    // R8: flag only drops on a software write
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.flag && !wr_ctrl) |=> ctrl_q.flag);

endmodule

// File: rtl/wdp_prescaler.sv
module wdp_prescaler
    import wdp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  ratio_sel_e sel,
    output logic       tick
);

    logic [DIV_W-1:0]    div_q;
    logic [NUM_TAPS-1:0] tap_hit;

    always_ff @(posedge clk) begin
        if (rst || !run)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        localparam logic [DIV_W-1:0] MASK = tap_mask(g);
        assign tap_hit[g] = ((div_q & MASK) == MASK);
    end

    assign tick = run && tap_hit[sel];

    // R6: divider restarts from zero when stopped
    p_div_clear_r6: assert property (@(posedge clk) disable iff (rst)
        !run |=> div_q == '0);

    // R4: divided ratios never tick on two cycles in a row
    p_tick_spacing_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && sel != RATIO_1) |=> !tick);

endmodule

// File: rtl/wdp_counter.sv
module wdp_counter
    import wdp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wrap_evt,
    output logic             ovf_pulse_q
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    assign wrap_evt = tick && !load && (cnt_q == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q       <= '0;
            ovf_pulse_q <= 1'b0;
        end else begin
            ovf_pulse_q <= wrap_evt;
            if (load)
                cnt_q <= load_val;
            else if (tick)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9: load wins over increment
    p_load_wins_r9: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt_q == $past(load_val));

    // R3: no tick, no load -> value retained
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cnt_q));

    // R7: pulse coincides with a zero count and lasts one cycle
    p_pulse_zero_r7: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse_q |-> cnt_q == '0);
    p_pulse_single_r7: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse_q |=> !ovf_pulse_q);

endmodule

// File: rtl/wdog_prescaled.sv
module wdog_prescaled
    import wdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              ovf_pulse
);

    ctrl_t            ctrl;
    logic             tick;
    logic             wrap_evt;
    logic [CNT_W-1:0] cnt;
    logic             wr_ctrl;
    logic             wr_cnt;

    assign wr_ctrl = bus_sel && bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_cnt  = bus_sel && bus_wr && (bus_addr == ADDR_CNT);

    wdp_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_ctrl  (wr_ctrl),
        .wr_flag  (bus_wdata[BIT_FLAG]),
        .wr_run   (bus_wdata[BIT_RUN]),
        .wr_sel   (bus_wdata[SEL_W-1:0]),
        .wrap_evt (wrap_evt),
        .ctrl_q   (ctrl)
    );

    wdp_prescaler u_presc (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl.run),
        .sel  (ctrl.sel),
        .tick (tick)
    );

    wdp_counter u_cnt (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .load        (wr_cnt),
        .load_val    (bus_wdata[CNT_W-1:0]),
        .cnt_q       (cnt),
        .wrap_evt    (wrap_evt),
        .ovf_pulse_q (ovf_pulse)
    );

    always_comb begin
        case (bus_addr)
            ADDR_CTRL: bus_rdata = ctrl_image(ctrl);
            ADDR_CNT:  bus_rdata = cnt;
            default:   bus_rdata = '0;
        endcase
    end

    // R2: reserved control bits read back fixed
    p_rsv_bits_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_CTRL) |-> (bus_rdata[4:3] == 2'b11 && !bus_rdata[6]));

    // R8: every pulse leaves the flag set
    p_flag_on_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |-> ctrl.flag);

endmodule

// File: tb/wdog_prescaled_bench.sv
module wdog_prescaled_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ovf_pulse;

    int checks = 0;
    int errors = 0;
    int pulse_cnt = 0;
    int wide_pulse = 0;
    logic prev_pulse = 1'b0;

    always #4 clk = ~clk;

    wdog_prescaled u_wdog_prescaled (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ovf_pulse(ovf_pulse)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (ovf_pulse) pulse_cnt++;
            if (ovf_pulse && prev_pulse) wide_pulse++;
            prev_pulse <= ovf_pulse;
        end
    end

    function automatic int ratio_of(input int s);
        case (s)
            0: return 1;       1: return 64;    2: return 128;  3: return 256;
            4: return 512;     5: return 1024;  6: return 4096; default: return 16384;
        endcase
    endfunction

    function automatic logic [7:0] ctrl_wr(input logic f, input logic r, input int s);
        return {f, 1'b0, r, 2'b00, 3'(s)};
    endfunction

    function automatic logic [7:0] ctrl_exp(input logic f, input logic r, input int s);
        return {f, 1'b0, r, 2'b11, 3'(s)};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge after the write edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int seed;
        int unused_r;
        seed = 32'h5eed;
        unused_r = $urandom(seed);

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset values
        rd(2'd0, v); chk("R1 ctrl", v, 8'h18);
        rd(2'd1, v); chk("R1 cnt", v, 8'h00);
        chk("R1 pulse", ovf_pulse, 0);

        // R2: reserved bits and unused addresses
        wr(2'd0, 8'b0101_1010);
        rd(2'd0, v); chk("R2 rsv", v, 8'h1A);
        wr(2'd0, 8'h42);
        rd(2'd0, v); chk("R2 rsv2", v, 8'h1A);
        rd(2'd2, v); chk("R2 addr2", v, 8'h00);
        rd(2'd3, v); chk("R2 addr3", v, 8'h00);

        // R5: selection lock
        wr(2'd0, 8'h23);
        rd(2'd0, v); chk("R5 accept", v, 8'h3B);
        wr(2'd0, 8'h26);
        rd(2'd0, v); chk("R5 locked", v, 8'h3B);
        wr(2'd0, 8'h05);
        rd(2'd0, v); chk("R5 stop keeps", v, 8'h1B);
        wr(2'd0, 8'h05);
        rd(2'd0, v); chk("R5 stopped", v, 8'h1D);

        // R6 / R3: divider restart at ratio 256
        wr(2'd0, 8'h03);
        wr(2'd1, 8'h10);
        wr(2'd0, 8'h23);
        wait_n(200);
        wr(2'd0, 8'h03);
        wait_n(30);
        rd(2'd1, v); chk("R3 hold", v, 8'h10);
        wr(2'd0, 8'h23);
        wait_n(255);
        rd(2'd1, v); chk("R6 before", v, 8'h10);
        wait_n(1);
        rd(2'd1, v); chk("R6 first tick", v, 8'h11);

        // R9: load priority at ratio 1
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h20);
        wr(2'd1, 8'h40);
        rd(2'd1, v); chk("R9 load", v, 8'h40);
        wait_n(5);
        rd(2'd1, v); chk("R4 ratio1", v, 8'h45);

        // R7 / R8: wrap
        wr(2'd1, 8'hFE);
        rd(2'd1, v); chk("R9 load FE", v, 8'hFE);
        chk("R7 no pulse", ovf_pulse, 0);
        wait_n(1);
        chk("R7 no pulse FF", ovf_pulse, 0);
        wait_n(1);
        rd(2'd1, v); chk("R7 cnt zero", v, 8'h00);
        chk("R7 pulse", ovf_pulse, 1);
        wait_n(1);
        chk("R7 pulse drop", ovf_pulse, 0);
        rd(2'd0, v); chk("R8 flag set", v, 8'hB8);
        wr(2'd0, 8'hA0);
        rd(2'd0, v); chk("R8 write1 keeps", v, 8'hB8);
        wr(2'd0, 8'h20);
        rd(2'd0, v); chk("R8 cleared", v, 8'h38);
        chk("R7 width", wide_pulse, 0);

        // R4 / R3 / R7 / R8: randomised runs
        for (int it = 0; it < 14; it++) begin
            int s, r, k, start, inc, wraps, p0;
            s = $urandom_range(0, 5);
            r = ratio_of(s);
            k = (s == 0) ? $urandom_range(0, 600) : $urandom_range(0, 3 * r);
            start = (it % 2 == 0) ? $urandom_range(0, 255) : $urandom_range(250, 255);
            wr(2'd0, 8'h00);
            wr(2'd0, ctrl_wr(1'b0, 1'b0, s));
            wr(2'd1, 8'(start));
            p0 = pulse_cnt;
            wr(2'd0, ctrl_wr(1'b0, 1'b1, s));
            wait_n(k);
            inc = k / r;
            rd(2'd1, v); chk("R4 rate", v, (start + inc) % 256);
            wr(2'd0, ctrl_wr(1'b1, 1'b0, s));
            inc = (k + 1) / r;
            wraps = (start + inc) / 256;
            wait_n(20);
            rd(2'd1, v); chk("R3 frozen", v, (start + inc) % 256);
            rd(2'd0, v); chk("R8 flag", v, ctrl_exp(wraps > 0, 1'b0, s));
            chk("R7 pulses", pulse_cnt - p0, wraps);
        end
        chk("R7 width end", wide_pulse, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule